// File: doc/BRIEF.md
# Pipelined Burst SRAM Model

A synthesizable, clock-accurate model of a synchronous pipelined burst SRAM whose bus never needs an idle turnaround cycle between reads and writes. Each enabled rising edge either starts an access at a freshly loaded address, steps an internal two-bit burst counter to continue the previous access, or deselects the device. Reads return data one enabled cycle after their address edge. Writes take their data one enabled cycle after their address edge. Because both follow the same one-cycle schedule, reads and writes can be issued on consecutive edges.

The 36-bit word is divided into four byte lanes. Each lane holds eight data bits and one parity bit, and each lane has its own active-low write strobe. The data pad is split into an input bus, an output bus and an output-drive flag. A clock-enable stretches the current cycle without deselecting the device. A sleep input freezes all activity and keeps the stored words intact. A static order input chooses between linear and interleaved bursts. The depth is a small parameter so that the model stays cheap to simulate.

Top module: `burst_sram`

## Requirements
- R1: After reset no access is in progress: `dq_oe` is 0, and an advance edge performs no access until a selected load edge occurs.
- R2: A load edge (`cen_n`=0, `sleep`=0, `advance`=0) starts an access only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other combination deselects the device, and `dq_oe` is 0 in the following cycle.
- R3: A selected load edge with `we_n`=1 is a read. In the cycle after that edge, `dout` carries the word stored at `addr`, and `dq_oe` is 1 if `oe_n`=0.
- R4: With `order_ilv`=0 the n-th advance after a load at address A accesses address bits [1:0] = (A[1:0]+n) mod 4. The upper address bits stay at A's upper bits.
- R5: With `order_ilv`=1 the n-th advance accesses bits [1:0] = A[1:0] XOR (n mod 4). The upper bits are unchanged.
- R6: An advance edge that follows a deselect performs no access and drives nothing. On advance edges the chip enables and `we_n` are ignored, and the burst keeps the read/write type of its load edge.
- R7: An edge with `cen_n`=1 is ignored entirely. Burst position, pending write and output data are held, so the previous cycle is stretched.
- R8: A write's data is taken from `din` at the next enabled edge. Lane i holds data bits [8i+7:8i] and parity bit 32+i. The lane is written only if `bw_n[i]`=0 on the write's address edge; other lanes keep their contents.
- R9: A read issued on the edge that captures a preceding write's data to the same address returns the newly written lanes merged with the untouched ones.
- R10: `dq_oe` is 1 only when `oe_n`=0 and the previous enabled edge performed a read. It is 0 during a write's data cycle, in the first cycle after a deselect and while deselected.
- R11: While `sleep`=1, edges are ignored as with `cen_n`=1, `dq_oe` is 0, and stored words are preserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset of the control state |
| cen_n | input | 1 | Active-low clock enable |
| sleep | input | 1 | Active-high freeze; contents kept |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| advance | input | 1 | 1 = step burst counter, 0 = load new address |
| we_n | input | 1 | Active-low write select on load edges |
| bw_n | input | 4 | Active-low per-lane write strobes |
| addr | input | 6 | Word address |
| order_ilv | input | 1 | Burst order: 1 interleaved, 0 linear; static |
| oe_n | input | 1 | Active-low output enable |
| din | input | 36 | Write data |
| dout | output | 36 | Read data, zero when not driving |
| dq_oe | output | 1 | Output drive flag |

## Verification
The hardest case to reach is one where several timing rules act at once. A pending write's data edge coincides with a read of that same address. At the same time, a clock-enable stall or a sleep pulse falls between the two edges, or the burst counter wraps past its fourth beat. Directed sequences place a read at exactly that data edge, with and without masked lanes. A seeded random phase then mixes stalls, sleep, deselects, advances after deselects and order changes. A behavioural reference in the bench is compared on every cycle, so these overlaps are checked as they occur and not only at the end of a burst.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
   typedef enum logic {
      ORDER_LINEAR      = 1'b0,
      ORDER_INTERLEAVED = 1'b1
   } burst_order_e;

   localparam int unsigned BURST_W = 2;
endpackage

// File: rtl/burst_sram_addr.sv
module burst_sram_addr
   import burst_sram_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned STEP_W = BURST_W
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [STEP_W-1:0] step,
   input  burst_order_e      order,
   output logic [ADDR_W-1:0] acc_addr
);
   logic [STEP_W-1:0] low_lin, low_ilv, low_sel;

   assign low_lin = base[STEP_W-1:0] + step;
   assign low_ilv = base[STEP_W-1:0] ^ step;
   assign low_sel = (order == ORDER_INTERLEAVED) ? low_ilv : low_lin;

   generate
      if (ADDR_W > STEP_W) begin : g_hi
         assign acc_addr = {base[ADDR_W-1:STEP_W], low_sel};
      end else begin : g_lo
         assign acc_addr = low_sel;
      end
   endgenerate
endmodule

// File: rtl/burst_sram_ctrl.sv
module burst_sram_ctrl
   import burst_sram_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned LANES  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              load,
   input  logic              sel,
   input  logic              wr_req,
   input  logic [ADDR_W-1:0] addr,
   input  logic [LANES-1:0]  bw_n,
   input  burst_order_e      order,
   output logic              fire,
   output logic              is_wr,
   output logic [ADDR_W-1:0] acc_addr,
   output logic              pend_v,
   output logic [ADDR_W-1:0] pend_addr,
   output logic [LANES-1:0]  pend_be,
   output logic              rd_valid,
   output logic              active
);
   logic              wr_q;
   logic [ADDR_W-1:0] base_q, base_c;
   logic [BURST_W-1:0] step_q, step_c;

   assign step_c = load ? '0 : step_q + 1'b1;
   assign base_c = load ? addr : base_q;
   assign fire   = load ? sel : active;
   assign is_wr  = load ? wr_req : wr_q;

   burst_sram_addr #(.ADDR_W(ADDR_W), .STEP_W(BURST_W)) u_addr (
      .base     (base_c),
      .step     (step_c),
      .order    (order),
      .acc_addr (acc_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active    <= 1'b0;
         wr_q      <= 1'b0;
         base_q    <= '0;
         step_q    <= '0;
         pend_v    <= 1'b0;
         pend_addr <= '0;
         pend_be   <= '0;
         rd_valid  <= 1'b0;
      end else if (en) begin
         if (load) begin
            active <= sel;
            wr_q   <= wr_req;
            base_q <= addr;
         end
         step_q    <= step_c;
         pend_v    <= fire & is_wr;
         pend_addr <= acc_addr;
         pend_be   <= ~bw_n;
         rd_valid  <= fire & ~is_wr;
      end
   end
endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned DATA_W = LANES * LANE_W,
   localparam int unsigned WORD_W = LANES * (LANE_W + 1),
   localparam int unsigned DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              en,
   input  logic              pend_v,
   input  logic [ADDR_W-1:0] pend_addr,
   input  logic [LANES-1:0]  pend_be,
   input  logic [WORD_W-1:0] din,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [WORD_W-1:0] rd_data
);
   logic [WORD_W-1:0] mem [DEPTH];
   logic [WORD_W-1:0] old_word, new_word, rd_word;

   assign old_word = mem[pend_addr];

   generate
      for (genvar i = 0; i < LANES; i++) begin : g_lane
         assign new_word[i*LANE_W +: LANE_W] = pend_be[i] ? din[i*LANE_W +: LANE_W]
                                                          : old_word[i*LANE_W +: LANE_W];
         assign new_word[DATA_W + i] = pend_be[i] ? din[DATA_W + i] : old_word[DATA_W + i];
      end
   endgenerate

   assign rd_word = (pend_v && (pend_addr == rd_addr)) ? new_word : mem[rd_addr];

   always_ff @(posedge clk) begin
      if (en) begin
         if (pend_v) mem[pend_addr] <= new_word;
         if (rd_en)  rd_data <= rd_word;
      end
   end
endmodule

// File: rtl/burst_sram.sv
module burst_sram
   import burst_sram_pkg::*;
#(
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned LANES  = 4,
   parameter int unsigned LANE_W = 8,
   localparam int unsigned WORD_W = LANES * (LANE_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cen_n,
   input  logic              sleep,
   input  logic              ce1_n,
   input  logic              ce2,
   input  logic              ce3_n,
   input  logic              advance,
   input  logic              we_n,
   input  logic [LANES-1:0]  bw_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              order_ilv,
   input  logic              oe_n,
   input  logic [WORD_W-1:0] din,
   output logic [WORD_W-1:0] dout,
   output logic              dq_oe
);
   generate
      if (ADDR_W < BURST_W) begin : g_bad_addr
         $error("burst_sram: ADDR_W must cover the burst offset");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("burst_sram: lane geometry must be non-empty");
      end
   endgenerate

   logic              en, sel, fire, is_wr, pend_v, rd_valid, active;
   logic [ADDR_W-1:0] acc_addr, pend_addr;
   logic [LANES-1:0]  pend_be;
   logic [WORD_W-1:0] rd_data;
   burst_order_e      order;

   assign en    = ~cen_n & ~sleep;
   assign sel   = ~ce1_n & ce2 & ~ce3_n;
   assign order = burst_order_e'(order_ilv);

   burst_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .en        (en),
      .load      (~advance),
      .sel       (sel),
      .wr_req    (~we_n),
      .addr      (addr),
      .bw_n      (bw_n),
      .order     (order),
      .fire      (fire),
      .is_wr     (is_wr),
      .acc_addr  (acc_addr),
      .pend_v    (pend_v),
      .pend_addr (pend_addr),
      .pend_be   (pend_be),
      .rd_valid  (rd_valid),
      .active    (active)
   );

   burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk       (clk),
      .en        (en),
      .pend_v    (pend_v),
      .pend_addr (pend_addr),
      .pend_be   (pend_be),
      .din       (din),
      .rd_en     (fire & ~is_wr),
      .rd_addr   (acc_addr),
      .rd_data   (rd_data)
   );

   assign dq_oe = rd_valid & ~oe_n & ~sleep;
   assign dout  = dq_oe ? rd_data : '0;
endmodule

// File: rtl/burst_sram_chk.sv
module burst_sram_chk (
   input logic clk,
   input logic rst_n,
   input logic cen_n,
   input logic sleep,
   input logic ce1_n,
   input logic ce2,
   input logic ce3_n,
   input logic advance,
   input logic we_n,
   input logic oe_n,
   input logic dq_oe,
   input logic rd_valid,
   input logic active
);
   logic go, picked;
   assign go     = !cen_n && !sleep;
   assign picked = !ce1_n && ce2 && !ce3_n;

   p_pin_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> !oe_n);

   p_sleep_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |-> !dq_oe);

   p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !go |=> ($stable(rd_valid) && $stable(active)));

   p_deselect_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !advance && !picked) |=> (!dq_oe && !active));

   p_write_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !advance && picked && !we_n) |=> !dq_oe);

   p_adv_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (go && advance && !active) |=> !rd_valid);

   p_read_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (go && !advance && picked && we_n) |=> rd_valid);
endmodule

bind burst_sram burst_sram_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cen_n    (cen_n),
   .sleep    (sleep),
   .ce1_n    (ce1_n),
   .ce2      (ce2),
   .ce3_n    (ce3_n),
   .advance  (advance),
   .we_n     (we_n),
   .oe_n     (oe_n),
   .dq_oe    (dq_oe),
   .rd_valid (rd_valid),
   .active   (active)
);

// File: tb/test_burst_sram.sv
module test_burst_sram;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 6;
   localparam int NL = 4;
   localparam int WW = 36;

   logic clk = 0, rst_n = 0;
   logic cen_n = 0, sleep = 0, ce1_n = 1, ce2 = 0, ce3_n = 1, advance = 0, we_n = 1;
   logic [NL-1:0] bw_n = '1;
   logic [AW-1:0] addr = '0;
   logic order_ilv = 0, oe_n = 0;
   logic [WW-1:0] din = '0;
   logic [WW-1:0] dout;
   logic dq_oe;

   burst_sram i_burst_sram (
      .clk(clk), .rst_n(rst_n), .cen_n(cen_n), .sleep(sleep), .ce1_n(ce1_n),
      .ce2(ce2), .ce3_n(ce3_n), .advance(advance), .we_n(we_n), .bw_n(bw_n),
      .addr(addr), .order_ilv(order_ilv), .oe_n(oe_n), .din(din),
      .dout(dout), .dq_oe(dq_oe)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int checks = 0, errors = 0;
   bit done = 0;
   string tag = "R1";

   // behavioural reference
   logic [WW-1:0] ref_mem [1<<AW];
   bit m_active = 0, m_wr = 0, m_pv = 0, m_rv = 0;
   logic [AW-1:0] m_base = '0, m_pa = '0;
   int m_n = 0;
   logic [NL-1:0] m_pbe = '0;
   logic [WW-1:0] m_rd = '0;

   function automatic int offs(int s, int n, bit ilv);
      if (ilv) return s ^ (n % 4);
      return (s + n) % 4;
   endfunction

   function automatic logic [WW-1:0] pat(int a, int k);
      logic [WW-1:0] v;
      v = 36'h5_A5A5_0000 ^ (36'(a) * 36'h0_0103_0507) ^ 36'(k * 977);
      return v;
   endfunction

   task automatic check(string t, logic [WW-1:0] act, logic [WW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", t, act, exp, $time);
      end
   endtask

   task automatic step();
      bit fire;
      int a;
      bit exp_oe;
      @(posedge clk);
      if (rst_n && !cen_n && !sleep) begin
         if (m_pv)
            for (int i = 0; i < NL; i++)
               if (m_pbe[i]) begin
                  ref_mem[m_pa][i*8 +: 8] = din[i*8 +: 8];
                  ref_mem[m_pa][32+i]     = din[32+i];
               end
         fire = 0;
         if (!advance) begin
            if (!ce1_n && ce2 && !ce3_n) begin
               m_active = 1; m_wr = !we_n; m_base = addr; m_n = 0; fire = 1;
            end else m_active = 0;
         end else if (m_active) begin
            m_n++; fire = 1;
         end
         a = (int'(m_base) / 4) * 4 + offs(int'(m_base) % 4, m_n, order_ilv);
         m_pv = fire && m_wr;
         m_pa = AW'(a);
         m_pbe = ~bw_n;
         m_rv = fire && !m_wr;
         if (m_rv) m_rd = ref_mem[a];
      end
      @(negedge clk);
      exp_oe = m_rv && !oe_n && !sleep;
      check({tag, " oe"}, {35'b0, dq_oe}, {35'b0, exp_oe});
      if (exp_oe) check({tag, " data"}, dout, m_rd);
   endtask

   task automatic op(bit adv, int a, bit wn, logic [NL-1:0] bw, logic [WW-1:0] d);
      cen_n = 0; advance = adv; addr = AW'(a); we_n = wn; bw_n = bw; din = d;
      ce1_n = 0; ce2 = 1; ce3_n = 0;
      step();
   endtask

   task automatic desel(logic [WW-1:0] d);
      cen_n = 0; advance = 0; ce1_n = 1; ce2 = 1; ce3_n = 0; we_n = 1; din = d;
      step();
   endtask

   task automatic stall();
      cen_n = 1; advance = 0; ce1_n = 1; ce2 = 0; we_n = 0; din = '1;
      step();
      cen_n = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      tag = "R1";
      check("R1 reset oe", {35'b0, dq_oe}, 36'b0);
      op(1, 3, 1, '1, '0);            // R1: advance after reset does nothing
      op(1, 3, 1, '1, '0);

      // fill memory with back-to-back writes (R8)
      tag = "R8";
      for (int a = 0; a < 64; a++) op(0, a, 0, '0, (a == 0) ? '0 : pat(a-1, 0));
      desel(pat(63, 0));

      // R3 single read and R4/R5 bursts from every offset, with wrap
      for (int md = 0; md < 2; md++) begin
         order_ilv = md[0];
         tag = md ? "R5" : "R4";
         for (int s = 0; s < 4; s++) begin
            op(0, 16 + s + 4*md, 1, '1, '0);
            for (int k = 0; k < 5; k++) op(1, 0, 0, '0, '0);
            desel('0);
         end
      end
      tag = "R3";
      op(0, 9, 1, '1, '0);
      desel('0);

      // write burst interleaved, read back linear (R5, R12-style type hold R6)
      tag = "R6";
      order_ilv = 1;
      op(0, 42, 0, '0, '0);
      for (int k = 1; k < 4; k++) begin
         ce1_n = 1;
         cen_n = 0; advance = 1; we_n = 1; din = pat(42, k);
         step();
      end
      desel(pat(42, 4));
      order_ilv = 0;
      op(0, 40, 1, '1, '0);
      for (int k = 0; k < 3; k++) op(1, 0, 1, '1, '0);
      desel('0);

      // stalls mid read burst and mid write (R7)
      tag = "R7";
      op(0, 24, 1, '1, '0);
      stall();
      op(1, 0, 1, '1, '0);
      stall(); stall();
      op(1, 0, 1, '1, '0);
      op(0, 50, 0, '0, '0);
      stall();
      op(0, 50, 1, '1, pat(50, 7));
      desel('0);

      // masked byte writes (R8)
      tag = "R8";
      op(0, 5, 0, 4'b1010, '0);
      op(0, 5, 1, '1, '1);
      desel('0);
      op(0, 5, 1, '1, '0);
      desel('0);

      // alternating write/read, same and other address (R9)
      tag = "R9";
      for (int i = 0; i < 8; i++) begin
         op(0, 30 + (i % 2), 0, 4'(i), '0);
         op(0, 30, 1, '1, pat(i, 11));
      end
      desel('0);

      // each chip enable deselects, then advance does nothing (R2, R6)
      tag = "R2";
      for (int c = 0; c < 3; c++) begin
         op(0, 12, 1, '1, '0);
         cen_n = 0; advance = 0; we_n = 1;
         ce1_n = (c == 0); ce2 = (c != 1); ce3_n = (c == 2);
         step();
         op(1, 0, 1, '1, '0);
         op(1, 0, 1, '1, '0);
      end

      // output enable pin high during read (R10)
      tag = "R10";
      op(0, 7, 1, '1, '0);
      oe_n = 1;
      op(1, 0, 1, '1, '0);
      oe_n = 0;
      op(1, 0, 1, '1, '0);
      desel('0);

      // sleep mid burst (R11)
      tag = "R11";
      op(0, 33, 1, '1, '0);
      sleep = 1;
      op(0, 60, 0, '0, '0);
      op(0, 61, 0, '0, '0);
      sleep = 0;
      op(1, 0, 1, '1, '0);
      op(1, 0, 1, '1, '0);
      desel('0);
      op(0, 60, 1, '1, '0);
      desel('0);

      // seeded random mix (R10 overall output rule)
      tag = "R10";
      begin
         int seed = 7;
         void'($urandom(seed));
      end
      for (int i = 0; i < 600; i++) begin
         if (i % 150 == 0) begin desel('0); order_ilv = ~order_ilv; end
         cen_n   = ($urandom % 8) == 0;
         sleep   = ($urandom % 16) == 0;
         advance = $urandom % 2;
         ce1_n   = ($urandom % 6) == 0;
         ce2     = ($urandom % 6) != 0;
         ce3_n   = ($urandom % 6) == 0;
         we_n    = $urandom % 2;
         bw_n    = NL'($urandom);
         addr    = AW'($urandom);
         oe_n    = ($urandom % 8) == 0;
         din     = {4'($urandom), 32'($urandom)};
         step();
      end
      sleep = 0; cen_n = 0; oe_n = 0;
      desel('0);

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule